// File: doc/BRIEF.md
# Logic Analyzer Command Receiver

This block sits behind a serial byte link and turns the incoming stream into the configuration and control of a simple logic-analyzer capture engine. Bytes arrive on a valid/data pair, one byte per cycle when valid is high. A byte with its top bit clear is a complete one-byte command. A byte with its top bit set is the opcode of a five-byte command, whose last four bytes give a 32-bit argument in little-endian order.

Five-byte commands load the configuration registers: the sample clock divider, the total and post-trigger sample counts, the channel-group flags with the sample width derived from them, and the mask, value and configuration of each trigger stage. One-byte commands give single-cycle action pulses for reset, arm, identification request and finish. Any command that changes the divider, counts or flags also gives a stop pulse, so a capture in progress halts before its timing is changed. The capture engine and the reply generator read these outputs.

Top module: `sump_cmd_rx`

## Requirements
- R1: A byte accepted with its bit 7 clear is a one-byte command. A byte with bit 7 set starts a command that completes on the fourth accepted byte after it. The argument is byte1 | byte2<<8 | byte3<<16 | byte4<<24. Cycles with in_valid low are skipped and do not count as bytes.
- R2: Opcode 0x80 loads divider with the argument plus one, modulo 2^32.
- R3: Opcode 0x81 sets delay_count = (arg[31:16]+1)*4 and read_count = (arg[15:0]+1)*4. If that delay_count is larger than that read_count, read_count takes the delay_count value.
- R4: Opcode 0x82 stores the argument in flags. Bits 2, 3, 4 and 5 disable channel groups 0 to 3. sample_width is 2 minus the number of groups 0 and 1 that are disabled. It is 0 when group 2 or group 3 is not disabled.
- R5: Opcodes 0xC0+4*s, 0xC1+4*s and 0xC2+4*s write the mask, the value and the configuration of trigger stage s (0..3). The configuration fields are: start = arg bit 27, serial = arg bit 25, level = arg bits 17:16, delay = arg bits 15:0, and channel = {arg bit 24, arg bits 23:20}.
- R6: Opcode 0x00 pulses reset_pulse, 0x01 and 0x0F pulse arm_pulse, 0x02 pulses id_pulse, and 0x05 pulses finish_pulse. Each pulse lasts exactly one cycle and starts on the second rising edge after the byte is accepted.
- R7: Opcodes 0x80, 0x81 and 0x82 each give exactly one stop_pulse. No other opcode gives one.
- R8: Opcode 0x00 clears every field of every trigger stage to zero. It leaves divider, counts and flags unchanged.
- R9: Any other opcode changes no output and gives no pulse. An unknown long opcode (for example 0x83 or 0xC3) still consumes its four argument bytes.
- R10: After reset: divider 1000, read_count 256, delay_count 256, flags 0x38, sample_width 1, all trigger fields zero, and all pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | in_data holds a byte this cycle |
| in_data | input | 8 | Received byte |
| divider | output | 32 | Sample clock divider |
| read_count | output | 19 | Total samples to return |
| delay_count | output | 19 | Samples to take after the trigger |
| flags | output | 32 | Raw flag word |
| sample_width | output | 2 | Bytes per sample, 0 means the configuration is invalid |
| trig_mask | output | 32*STAGES | Mask of each trigger stage, stage s in bits [32s+31:32s] |
| trig_value | output | 32*STAGES | Compare value of each trigger stage |
| trig_start | output | STAGES | Start flag of each stage |
| trig_serial | output | STAGES | Serial-mode flag of each stage |
| trig_level | output | 2*STAGES | Level of each stage |
| trig_channel | output | 5*STAGES | Serial channel of each stage |
| trig_delay | output | 16*STAGES | Delay of each stage |
| reset_pulse | output | 1 | Reset command seen |
| arm_pulse | output | 1 | Arm command seen |
| id_pulse | output | 1 | Identification request seen |
| finish_pulse | output | 1 | Finish command seen |
| stop_pulse | output | 1 | Timing configuration changed, halt capture |

## Verification
The most dangerous internal error is a byte counter that is out of step with the stream. It does not show on its own. It appears on the next command, when an argument byte is taken as an opcode, so a register gets a wrong value or a pulse fires where none is expected. The bench therefore sends a one-byte command straight after each unknown long command. A wrong decode of counts or flags shows on the outputs two edges after the last byte. A missing or repeated stop or action pulse shows in the pulse counts taken over each command.

// File: rtl/sump_rx_pkg.sv
package sump_rx_pkg;

    localparam int ARG_W = 32;
    localparam int CNT_W = 19;
    localparam int BYTE_W = 8;

    localparam logic [7:0] OP_RESET   = 8'h00;
    localparam logic [7:0] OP_ARM     = 8'h01;
    localparam logic [7:0] OP_ID      = 8'h02;
    localparam logic [7:0] OP_FINISH  = 8'h05;
    localparam logic [7:0] OP_ARM_ALT = 8'h0F;
    localparam logic [7:0] OP_DIV     = 8'h80;
    localparam logic [7:0] OP_COUNTS  = 8'h81;
    localparam logic [7:0] OP_FLAGS   = 8'h82;

    localparam logic [ARG_W-1:0] DIV_RST   = 32'd1000;
    localparam logic [CNT_W-1:0] COUNT_RST = 19'd256;
    localparam logic [ARG_W-1:0] FLAGS_RST = 32'h0000_0038;

    localparam int GRP0_BIT = 2;

    typedef struct packed {
        logic [7:0]       op;
        logic [ARG_W-1:0] arg;
    } cmd_t;

    typedef struct packed {
        logic [31:0] mask;
        logic [31:0] value;
        logic        start;
        logic        serial;
        logic [1:0]  level;
        logic [4:0]  channel;
        logic [15:0] delay;
    } trig_t;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_RESET,
        ACT_ARM,
        ACT_ID,
        ACT_FINISH,
        ACT_STOP
    } act_e;

    typedef enum logic [1:0] {
        TK_MASK  = 2'd0,
        TK_VALUE = 2'd1,
        TK_CFG   = 2'd2,
        TK_NONE  = 2'd3
    } tkind_e;

    function automatic logic [CNT_W-1:0] field_count(input logic [15:0] f);
        return (CNT_W'(f) + CNT_W'(1)) << 2;
    endfunction

    function automatic logic [1:0] width_of(input logic [ARG_W-1:0] f);
        logic [1:0] w;
        w = 2'd2 - 2'(f[GRP0_BIT]) - 2'(f[GRP0_BIT+1]);
        if (!f[GRP0_BIT+2] || !f[GRP0_BIT+3])
            w = 2'd0;
        return w;
    endfunction

endpackage

// File: rtl/sump_cmd_asm.sv
module sump_cmd_asm
    import sump_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              cmd_valid,
    output cmd_t              cmd
);
    localparam int ARG_BYTES = ARG_W / BYTE_W;

    logic [2:0]       cnt;
    logic [7:0]       op_q;
    logic [ARG_W-1:0] arg_q;
    logic [ARG_W-1:0] arg_next;

    assign arg_next = {in_data, arg_q[ARG_W-1:BYTE_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            op_q      <= '0;
            arg_q     <= '0;
            cmd_valid <= 1'b0;
            cmd       <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (in_valid) begin
                if (cnt == 3'd0) begin
                    op_q <= in_data;
                    if (!in_data[BYTE_W-1]) begin
                        cmd_valid <= 1'b1;
                        cmd       <= '{op: in_data, arg: '0};
                    end else begin
                        cnt <= 3'd1;
                    end
                end else begin
                    arg_q <= arg_next;
                    if (cnt == 3'(ARG_BYTES)) begin
                        cmd_valid <= 1'b1;
                        cmd       <= '{op: op_q, arg: arg_next};
                        cnt       <= '0;
                    end else begin
                        cnt <= cnt + 3'd1;
                    end
                end
            end
        end
    end

    // R1: the byte counter never passes the argument length
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
        cnt <= 3'(ARG_BYTES));

    // R1: a long command completes only from the last argument byte
    p_long_len_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cnt == 3'(ARG_BYTES)) |=> (cmd_valid && cmd.op[7] && cnt == 3'd0));

endmodule

// File: rtl/sump_cfg_regs.sv
module sump_cfg_regs
    import sump_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  cmd_t             cmd,
    output logic [ARG_W-1:0] divider,
    output logic [CNT_W-1:0] read_count,
    output logic [CNT_W-1:0] delay_count,
    output logic [ARG_W-1:0] flags,
    output logic [1:0]       width,
    output act_e             act,
    output logic             trig_we,
    output logic [1:0]       trig_stage,
    output tkind_e           trig_kind,
    output logic             trig_clr
);
    logic [CNT_W-1:0] cnt_rd;
    logic [CNT_W-1:0] cnt_dl;

    always_comb begin
        cnt_rd     = field_count(cmd.arg[15:0]);
        cnt_dl     = field_count(cmd.arg[31:16]);
        trig_stage = cmd.op[3:2];
        trig_kind  = tkind_e'(cmd.op[1:0]);
        trig_we    = cmd_valid && cmd.op[7:4] == 4'hC && trig_kind != TK_NONE;
        trig_clr   = cmd_valid && cmd.op == OP_RESET;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            divider     <= DIV_RST;
            read_count  <= COUNT_RST;
            delay_count <= COUNT_RST;
            flags       <= FLAGS_RST;
            width       <= width_of(FLAGS_RST);
            act         <= ACT_NONE;
        end else begin
            act <= ACT_NONE;
            if (cmd_valid) begin
                case (cmd.op)
                    OP_RESET:           act <= ACT_RESET;
                    OP_ARM, OP_ARM_ALT: act <= ACT_ARM;
                    OP_ID:              act <= ACT_ID;
                    OP_FINISH:          act <= ACT_FINISH;
                    OP_DIV: begin
                        divider <= cmd.arg + 32'd1;
                        act     <= ACT_STOP;
                    end
                    OP_COUNTS: begin
                        delay_count <= cnt_dl;
                        read_count  <= (cnt_dl > cnt_rd) ? cnt_dl : cnt_rd;
                        act         <= ACT_STOP;
                    end
                    OP_FLAGS: begin
                        flags <= cmd.arg;
                        width <= width_of(cmd.arg);
                        act   <= ACT_STOP;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3: the total count never falls below the post-trigger count
    p_read_ge_delay_r3: assert property (@(posedge clk) disable iff (rst)
        read_count >= delay_count);

    // R3: counts are nonzero multiples of four
    p_count_align_r3: assert property (@(posedge clk) disable iff (rst)
        read_count[1:0] == 2'b00 && delay_count[1:0] == 2'b00 && delay_count != '0);

    // R4: an enabled upper group always gives width zero
    p_width_upper_r4: assert property (@(posedge clk) disable iff (rst)
        (flags[GRP0_BIT+3:GRP0_BIT+2] != 2'b11) |-> width == 2'd0);

    // R4: the width is never three bytes
    p_width_legal_r4: assert property (@(posedge clk) disable iff (rst)
        width != 2'd3);

    // R7: a timing command is followed by a stop action
    p_stop_on_cfg_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd.op == OP_DIV || cmd.op == OP_COUNTS || cmd.op == OP_FLAGS))
        |=> act == ACT_STOP);

endmodule

// File: rtl/sump_trig_bank.sv
module sump_trig_bank
    import sump_rx_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       stage,
    input  tkind_e           kind,
    input  logic [ARG_W-1:0] data,
    input  logic             clr,
    output trig_t            trig [STAGES]
);
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                trig[s] <= '0;
            end else if (we && stage == 2'(s)) begin
                case (kind)
                    TK_MASK:  trig[s].mask  <= data;
                    TK_VALUE: trig[s].value <= data;
                    TK_CFG: begin
                        trig[s].start   <= data[27];
                        trig[s].serial  <= data[25];
                        trig[s].level   <= data[17:16];
                        trig[s].channel <= {data[24], data[23:20]};
                        trig[s].delay   <= data[15:0];
                    end
                    default: ;
                endcase
            end
        end

        // R8: a clear empties the stage on the next edge
        p_clear_r8: assert property (@(posedge clk) disable iff (rst)
            clr |=> (trig[s].mask == '0 && trig[s].value == '0 && !trig[s].start));
    end

endmodule

// File: rtl/sump_cmd_rx.sv
module sump_cmd_rx
    import sump_rx_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [7:0]          in_data,
    output logic [31:0]         divider,
    output logic [18:0]         read_count,
    output logic [18:0]         delay_count,
    output logic [31:0]         flags,
    output logic [1:0]          sample_width,
    output logic [32*STAGES-1:0] trig_mask,
    output logic [32*STAGES-1:0] trig_value,
    output logic [STAGES-1:0]   trig_start,
    output logic [STAGES-1:0]   trig_serial,
    output logic [2*STAGES-1:0] trig_level,
    output logic [5*STAGES-1:0] trig_channel,
    output logic [16*STAGES-1:0] trig_delay,
    output logic                reset_pulse,
    output logic                arm_pulse,
    output logic                id_pulse,
    output logic                finish_pulse,
    output logic                stop_pulse
);
    logic       cmd_valid;
    cmd_t       cmd;
    act_e       act;
    logic       t_we;
    logic [1:0] t_stage;
    tkind_e     t_kind;
    logic       t_clr;
    trig_t      trig [STAGES];

    sump_cmd_asm u_asm (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .cmd_valid (cmd_valid),
        .cmd       (cmd)
    );

    sump_cfg_regs u_cfg (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd         (cmd),
        .divider     (divider),
        .read_count  (read_count),
        .delay_count (delay_count),
        .flags       (flags),
        .width       (sample_width),
        .act         (act),
        .trig_we     (t_we),
        .trig_stage  (t_stage),
        .trig_kind   (t_kind),
        .trig_clr    (t_clr)
    );

    sump_trig_bank #(.STAGES(STAGES)) u_trig (
        .clk   (clk),
        .rst   (rst),
        .we    (t_we),
        .stage (t_stage),
        .kind  (t_kind),
        .data  (cmd.arg),
        .clr   (t_clr),
        .trig  (trig)
    );

    for (genvar s = 0; s < STAGES; s++) begin : g_flat
        assign trig_mask[32*s +: 32]    = trig[s].mask;
        assign trig_value[32*s +: 32]   = trig[s].value;
        assign trig_start[s]            = trig[s].start;
        assign trig_serial[s]           = trig[s].serial;
        assign trig_level[2*s +: 2]     = trig[s].level;
        assign trig_channel[5*s +: 5]   = trig[s].channel;
        assign trig_delay[16*s +: 16]   = trig[s].delay;
    end

    assign reset_pulse  = act == ACT_RESET;
    assign arm_pulse    = act == ACT_ARM;
    assign id_pulse     = act == ACT_ID;
    assign finish_pulse = act == ACT_FINISH;
    assign stop_pulse   = act == ACT_STOP;

    // R6: an action pulse never lasts two cycles for back-to-back idle input
    p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
        (arm_pulse && !$past(cmd_valid)) |=> !arm_pulse);

endmodule

// File: tb/sim_sump_cmd_rx.sv
module sim_sump_cmd_rx;
    localparam int STAGES = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic [31:0] divider, flags;
    logic [18:0] read_count, delay_count;
    logic [1:0] sample_width;
    logic [32*STAGES-1:0] trig_mask, trig_value;
    logic [STAGES-1:0] trig_start, trig_serial;
    logic [2*STAGES-1:0] trig_level;
    logic [5*STAGES-1:0] trig_channel;
    logic [16*STAGES-1:0] trig_delay;
    logic reset_pulse, arm_pulse, id_pulse, finish_pulse, stop_pulse;

    int checks = 0;
    int errors = 0;
    int n_rst = 0, n_arm = 0, n_id = 0, n_fin = 0, n_stop = 0;

    always #5 clk = ~clk;

    sump_cmd_rx #(.STAGES(STAGES)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .divider(divider), .read_count(read_count), .delay_count(delay_count),
        .flags(flags), .sample_width(sample_width),
        .trig_mask(trig_mask), .trig_value(trig_value), .trig_start(trig_start),
        .trig_serial(trig_serial), .trig_level(trig_level),
        .trig_channel(trig_channel), .trig_delay(trig_delay),
        .reset_pulse(reset_pulse), .arm_pulse(arm_pulse), .id_pulse(id_pulse),
        .finish_pulse(finish_pulse), .stop_pulse(stop_pulse)
    );

    always @(posedge clk) begin
        if (!rst) begin
            n_rst  += int'(reset_pulse);
            n_arm  += int'(arm_pulse);
            n_id   += int'(id_pulse);
            n_fin  += int'(finish_pulse);
            n_stop += int'(stop_pulse);
        end
    end

    typedef struct packed {
        logic [7:0]  op;
        logic [31:0] arg;
        logic [31:0] e1;
        logic [31:0] e2;
    } vec_t;

    // 0x80: e1 = divider; 0x81: e1 = read, e2 = delay; 0x82: e1 = width
    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{8'h80, 32'h0000_0000, 32'd1,      32'd0},
        '{8'h80, 32'h0001_869F, 32'd100000, 32'd0},
        '{8'h80, 32'hFFFF_FFFF, 32'd0,      32'd0},
        '{8'h81, 32'h0000_0000, 32'd4,      32'd4},
        '{8'h81, 32'h0003_00FF, 32'd1024,   32'd16},
        '{8'h81, 32'h00FF_0001, 32'd1024,   32'd1024},
        '{8'h81, 32'hFFFF_FFFF, 32'd262144, 32'd262144},
        '{8'h82, 32'h0000_003C, 32'd0,      32'd0},
        '{8'h82, 32'h0000_0030, 32'd2,      32'd0},
        '{8'h82, 32'h0000_0034, 32'd1,      32'd0},
        '{8'h82, 32'h0000_0038, 32'd1,      32'd0},
        '{8'h82, 32'h0000_0020, 32'd0,      32'd0},
        '{8'h82, 32'h0000_0010, 32'd0,      32'd0}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = 8'hA5;
        end
    endtask

    task automatic clr_mon();
        @(negedge clk);
        n_rst = 0; n_arm = 0; n_id = 0; n_fin = 0; n_stop = 0;
    endtask

    task automatic send_long(input logic [7:0] op, input logic [31:0] arg);
        put(op);
        for (int i = 0; i < 4; i++) put(arg[8*i +: 8]);
        idle(4);
    endtask

    task automatic send_short(input logic [7:0] op);
        put(op);
        idle(4);
    endtask

    task automatic pulses(input string req, input int r, input int a, input int d, input int f, input int s);
        check(req, 64'(n_rst), 64'(r));
        check(req, 64'(n_arm), 64'(a));
        check(req, 64'(n_id), 64'(d));
        check(req, 64'(n_fin), 64'(f));
        check(req, 64'(n_stop), 64'(s));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 divider", 64'(divider), 64'd1000);
        check("R10 read", 64'(read_count), 64'd256);
        check("R10 delay", 64'(delay_count), 64'd256);
        check("R10 flags", 64'(flags), 64'h38);
        check("R10 width", 64'(sample_width), 64'd1);
        check("R10 trig", 64'(trig_mask | trig_value), 64'd0);
        check("R10 pulses", 64'({reset_pulse, arm_pulse, id_pulse, finish_pulse, stop_pulse}), 64'd0);

        // R2 R3 R4 R7 table walk
        for (int v = 0; v < NV; v++) begin
            clr_mon();
            send_long(VEC[v].op, VEC[v].arg);
            case (VEC[v].op)
                8'h80: check("R2 divider", 64'(divider), 64'(VEC[v].e1));
                8'h81: begin
                    check("R3 read_count", 64'(read_count), 64'(VEC[v].e1));
                    check("R3 delay_count", 64'(delay_count), 64'(VEC[v].e2));
                end
                default: begin
                    check("R4 flags", 64'(flags), 64'(VEC[v].arg));
                    check("R4 width", 64'(sample_width), 64'(VEC[v].e1));
                end
            endcase
            check("R7 stop count", 64'(n_stop), 64'd1);
        end

        // R1 gaps between argument bytes, little-endian order
        clr_mon();
        put(8'h80); idle(3);
        put(8'h44); idle(1);
        put(8'h33); idle(2);
        put(8'h22);
        put(8'h11);
        idle(4);
        check("R1 gapped long argument", 64'(divider), 64'h1122_3345);

        // R1 back-to-back one-byte commands
        clr_mon();
        put(8'h02);
        put(8'h05);
        idle(4);
        pulses("R1 back-to-back short", 0, 0, 1, 1, 0);

        // R6 action pulses
        clr_mon(); send_short(8'h01); pulses("R6 arm 0x01", 0, 1, 0, 0, 0);
        clr_mon(); send_short(8'h0F); pulses("R6 arm 0x0F", 0, 1, 0, 0, 0);
        clr_mon(); send_short(8'h02); pulses("R6 id", 0, 0, 1, 0, 0);
        clr_mon(); send_short(8'h05); pulses("R6 finish", 0, 0, 0, 1, 0);

        // R6 exact pulse timing: high after second edge, one cycle only
        put(8'h01);
        @(negedge clk); in_valid = 1'b0;
        check("R6 pulse not yet", 64'(arm_pulse), 64'd0);
        @(negedge clk);
        check("R6 pulse high", 64'(arm_pulse), 64'd1);
        @(negedge clk);
        check("R6 pulse dropped", 64'(arm_pulse), 64'd0);
        idle(2);

        // R5 trigger stages
        send_long(8'hCC, 32'hDEAD_BEEF);
        send_long(8'hCD, 32'h1234_5678);
        send_long(8'hCE, 32'h0B92_5678);
        send_long(8'hC6, 32'h0000_0003);
        send_long(8'hC0, 32'h0000_00FF);
        check("R5 stage3 mask", 64'(trig_mask[96 +: 32]), 64'hDEAD_BEEF);
        check("R5 stage3 value", 64'(trig_value[96 +: 32]), 64'h1234_5678);
        check("R5 stage3 start", 64'(trig_start[3]), 64'd1);
        check("R5 stage3 serial", 64'(trig_serial[3]), 64'd1);
        check("R5 stage3 level", 64'(trig_level[6 +: 2]), 64'd2);
        check("R5 stage3 channel", 64'(trig_channel[15 +: 5]), 64'h19);
        check("R5 stage3 delay", 64'(trig_delay[48 +: 16]), 64'h5678);
        check("R5 stage1 cfg", 64'({trig_start[1], trig_serial[1], trig_level[2 +: 2], trig_delay[16 +: 16]}), 64'd3);
        check("R5 stage0 mask", 64'(trig_mask[31:0]), 64'hFF);
        check("R5 stage2 untouched", 64'(trig_mask[64 +: 32] | trig_value[64 +: 32]), 64'd0);

        // R9 unknown opcodes
        clr_mon();
        send_short(8'h04);
        send_short(8'h06);
        send_short(8'h7E);
        pulses("R9 unknown short", 0, 0, 0, 0, 0);
        clr_mon();
        put(8'h83);
        put(8'h02); put(8'h02); put(8'h02); put(8'h02);
        put(8'h02);
        idle(4);
        pulses("R9 unknown long consumes argument", 0, 0, 1, 0, 0);
        check("R9 divider kept", 64'(divider), 64'h1122_3345);
        check("R9 flags kept", 64'(flags), 64'h10);
        send_long(8'hC3, 32'h5555_5555);
        check("R9 0xC3 ignored", 64'(trig_mask[31:0]), 64'hFF);
        check("R9 0xC3 value", 64'(trig_value[31:0]), 64'd0);

        // R8 reset command
        clr_mon();
        send_short(8'h00);
        pulses("R8 reset pulse", 1, 0, 0, 0, 0);
        check("R8 masks cleared", 64'(trig_mask[63:0] | trig_mask[127:64]), 64'd0);
        check("R8 values cleared", 64'(trig_value[63:0] | trig_value[127:64]), 64'd0);
        check("R8 cfg cleared", 64'({trig_start, trig_serial, trig_level, trig_channel}), 64'd0);
        check("R8 delays cleared", 64'(trig_delay), 64'd0);
        check("R8 divider kept", 64'(divider), 64'h1122_3345);
        check("R8 counts kept", 64'({read_count, delay_count}), 64'({19'd262144, 19'd262144}));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule